// File: doc/BRIEF.md
# Three-Region Paged Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address for a paged memory with 512-byte pages. Bits 31:30 of the address pick a region, bits 29:9 give the 21-bit page number and bits 8:0 the byte offset. There are two per-process regions: the ascending region starts at address zero and grows upward, and the descending region sits just below 2^31 and grows downward. The shared system region starts at 2^31. The top quarter of the space is reserved.

Each region has a base and a length input, loaded by software. The system table base is a physical address, so a system page costs one page-table read. The two process table bases are system-space virtual addresses. A process page therefore costs two reads in sequence: first the system entry that maps the process entry's address, then the process entry itself. An eight-entry fully associative cache of finished translations removes these reads on a repeat access. A context-switch pulse flushes the process entries from the cache and keeps the system entries.

A client offers one request at a time with a valid/ready handshake and gets a one-cycle response pulse carrying either a physical address or a fault code. Page-table entries arrive over a request/acknowledge read port that may take any number of cycles.

Top module: `segx_xlate`

## Requirements
- R1: A request with address bits 31:30 equal to 3 faults with code 2 on the cycle after acceptance, and issues no memory read.
- R2: A length fault (code 1) is raised with no memory read when the page number is at or above the length in the ascending region (region 0) or the system region (region 2), or when it is below the length in the descending region (region 1).
- R3: On a system-region miss, exactly one read is made at sys_base + 4*page. The response address is {frame, offset}.
- R4: On a process-region miss, let E = region base + 4*page. If E[31:30] is not 2, or E[29:9] is not below sys_len, the result is code 1 with no read. Otherwise the first read is at sys_base + 4*E[29:9], and the second read is at {2'b00, frame of the first entry, E[8:0]}.
- R5: A page-table entry has bit 31 as valid, bit 30 as privileged-only, bit 29 as read-only, and bits 20:0 as the frame number. Bits 28:21 are ignored.
- R6: A clear valid bit in the system-level entry gives code 3. A clear valid bit in the process-level entry gives code 4. Every faulting response carries a zero address.
- R7: A user-mode access to a privileged-only page gives code 5, and so does a write to a read-only page. A successful response has code 0.
- R8: A request that hits the cache responds on the cycle after acceptance, makes no memory read, and returns the same result as a miss would.
- R9: A context_switch pulse while idle removes the cached process-region entries. A later access to such a page reads memory again, while cached system pages still hit.
- R10: req_ready is high only when idle. rsp_valid lasts one cycle. mem_req stays high with a stable mem_addr until mem_ack.
- R11: The cache holds 8 entries, each tagged by region and page. Every entry-valid translation fills one slot in round-robin order, so the ninth new page evicts the first of the previous eight.
- R12: After reset, req_ready is 1, rsp_valid is 0 and mem_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Translator idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user mode, 0 = privileged mode |
| req_write | input | 1 | 1 = write access |
| ctx_switch | input | 1 | Flush process-region cache entries |
| sys_base | input | 32 | Physical base of the system page table |
| sys_len | input | 21 | System table length in entries |
| asc_base | input | 32 | System-virtual base of the ascending-region table |
| asc_len | input | 21 | Ascending-region length |
| dsc_base | input | 32 | System-virtual base of the descending-region table |
| dsc_len | input | 21 | Lowest legal descending-region page |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | 32 | Page-table read physical address |
| mem_ack | input | 1 | Read data valid, one-cycle pulse |
| mem_rdata | input | 32 | Page-table entry read |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 3 | Fault code, 0 = none |
| rsp_paddr | output | 30 | Physical address, 0 on fault |

## Verification
The properties assume that mem_ack only comes while mem_req is high. They also assume that the base and length inputs stay constant while a translation is in flight, and that context_switch is only pulsed while the translator is idle. The stimulus changes the registers and pulses the context switch only between completed responses. The memory responder acknowledges only a pending read, after a random delay of zero to three cycles. Page-table contents are a fixed function of address, so a cached result always matches a fresh table walk.

// File: rtl/segx_pkg.sv
// Shared types for the segmented translator.
// Assumes 32-bit virtual addresses, 512-byte pages and 21-bit frame numbers.
package segx_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 9;
    localparam int VPN_W = VA_W - OFF_W - 2;
    localparam int PFN_W = 21;
    localparam int PA_W  = PFN_W + OFF_W;

    typedef enum logic [1:0] {
        RG_ASC = 2'd0,
        RG_DSC = 2'd1,
        RG_SYS = 2'd2,
        RG_RSV = 2'd3
    } region_t;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_LEN      = 3'd1,
        FLT_RSV      = 3'd2,
        FLT_SYS_INV  = 3'd3,
        FLT_PROC_INV = 3'd4,
        FLT_ACCESS   = 3'd5
    } fault_t;
endpackage

// File: rtl/segx_decode.sv
// Region decode, length checks and first-read address for a new request.
// Purely combinational. Assumes that the base and length inputs are stable.
module segx_decode
    import segx_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [VA_W-1:0]  sys_base,
    input  logic [VPN_W-1:0] sys_len,
    input  logic [VA_W-1:0]  asc_base,
    input  logic [VPN_W-1:0] asc_len,
    input  logic [VA_W-1:0]  dsc_base,
    input  logic [VPN_W-1:0] dsc_len,
    output region_t          region,
    output logic [VPN_W-1:0] vpn,
    output logic             rsv_flt,
    output logic             len_flt,
    output logic [VA_W-1:0]  spte_addr,
    output logic [OFF_W-1:0] pva_off
);
    logic             nested;
    logic             reg_bad;
    logic             pva_bad;
    logic [VA_W-1:0]  pva;
    logic [VPN_W-1:0] sys_idx;

    assign region  = region_t'(vaddr[VA_W-1 -: 2]);
    assign vpn     = vaddr[VA_W-3 -: VPN_W];
    assign nested  = (region == RG_ASC) || (region == RG_DSC);
    assign rsv_flt = (region == RG_RSV);
    assign pva     = ((region == RG_DSC) ? dsc_base : asc_base) + {{(VA_W-VPN_W-2){1'b0}}, vpn, 2'b00};
    assign pva_off = pva[OFF_W-1:0];

    // Per-region length check; the descending region rejects low page numbers.
    always_comb begin
        case (region)
            RG_ASC:  reg_bad = (vpn >= asc_len);
            RG_DSC:  reg_bad = (vpn <  dsc_len);
            RG_SYS:  reg_bad = (vpn >= sys_len);
            default: reg_bad = 1'b0;
        endcase
    end

    // A process table entry must itself sit inside the mapped system region.
    assign pva_bad   = nested && ((pva[VA_W-1 -: 2] != RG_SYS) || (pva[VA_W-3 -: VPN_W] >= sys_len));
    assign len_flt   = reg_bad || pva_bad;
    assign sys_idx   = nested ? pva[VA_W-3 -: VPN_W] : vpn;
    assign spte_addr = sys_base + {{(VA_W-VPN_W-2){1'b0}}, sys_idx, 2'b00};
endmodule

// File: rtl/segx_tlb.sv
// Fully associative translation cache with round-robin fill.
// Assumes that fill and flush never come in the same cycle and that a fill is always a new tag.
module segx_tlb
    import segx_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  region_t          lk_rg,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    output logic             hit_kern,
    output logic             hit_ro,
    input  logic             fill_en,
    input  region_t          fill_rg,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_kern,
    input  logic             fill_ro,
    input  logic             flush_proc
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic             v;
        region_t          rg;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             kern;
        logic             ro;
    } ent_t;

    ent_t               ents [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0]   ptr;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = ents[g].v && (ents[g].rg == lk_rg) && (ents[g].vpn == lk_vpn);
        end
    endgenerate

    // OR-select the single matching entry.
    always_comb begin
        hit      = |match;
        hit_pfn  = '0;
        hit_kern = 1'b0;
        hit_ro   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_pfn  = hit_pfn | ents[i].pfn;
                hit_kern = hit_kern | ents[i].kern;
                hit_ro   = hit_ro | ents[i].ro;
            end
        end
    end

    // Entry storage: process flush, round-robin fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
            ptr <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_proc && ents[i].rg != RG_SYS) ents[i].v <= 1'b0;
            end
            if (fill_en) begin
                ents[ptr] <= '{v: 1'b1, rg: fill_rg, vpn: fill_vpn, pfn: fill_pfn,
                               kern: fill_kern, ro: fill_ro};
                ptr <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/segx_xlate.sv
// Top of the translator: request handshake, table-walk sequencer and response register.
// Assumes that mem_ack only comes while mem_req is high, that bases and lengths are stable
// during a walk, and that ctx_switch is pulsed only while idle.
module segx_xlate
    import segx_pkg::*;
#(
    parameter int TLB_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        req_user,
    input  logic        req_write,
    input  logic        ctx_switch,
    input  logic [31:0] sys_base,
    input  logic [20:0] sys_len,
    input  logic [31:0] asc_base,
    input  logic [20:0] asc_len,
    input  logic [31:0] dsc_base,
    input  logic [20:0] dsc_len,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        rsp_valid,
    output logic [2:0]  rsp_fault,
    output logic [29:0] rsp_paddr
);
    typedef enum logic [1:0] {ST_IDLE, ST_SYSRD, ST_PROCRD, ST_RESP} st_t;

    st_t              st;
    region_t          rg_in, rg_q;
    logic [VPN_W-1:0] vpn_in, vpn_q;
    logic [OFF_W-1:0] off_q, pva_off_in, pva_off_q;
    logic             rsv_flt, len_flt, user_q, wr_q;
    logic [VA_W-1:0]  spte_addr, addr_q;
    fault_t           fault_q;
    logic [PA_W-1:0]  paddr_q;
    logic             hit, hit_kern, hit_ro, hit_bad;
    logic [PFN_W-1:0] hit_pfn;
    logic             pte_valid, pte_kern, pte_ro, prot_bad, accept, final_ok;
    logic [PFN_W-1:0] pte_pfn;
    logic [7:0]       unused_pte_bits;

    segx_decode u_decode (
        .vaddr(req_vaddr), .sys_base(sys_base), .sys_len(sys_len),
        .asc_base(asc_base), .asc_len(asc_len), .dsc_base(dsc_base), .dsc_len(dsc_len),
        .region(rg_in), .vpn(vpn_in), .rsv_flt(rsv_flt), .len_flt(len_flt),
        .spte_addr(spte_addr), .pva_off(pva_off_in)
    );

    assign pte_valid       = mem_rdata[31];
    assign pte_kern        = mem_rdata[30];
    assign pte_ro          = mem_rdata[29];
    assign unused_pte_bits = mem_rdata[28:21];
    assign pte_pfn         = mem_rdata[PFN_W-1:0];

    assign accept   = req_valid && (st == ST_IDLE);
    assign hit_bad  = (req_user && hit_kern) || (req_write && hit_ro);
    assign prot_bad = (user_q && pte_kern) || (wr_q && pte_ro);
    assign final_ok = mem_ack && pte_valid &&
                      (((st == ST_SYSRD) && (rg_q == RG_SYS)) || (st == ST_PROCRD));

    segx_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk(clk), .rst_n(rst_n), .lk_rg(rg_in), .lk_vpn(vpn_in),
        .hit(hit), .hit_pfn(hit_pfn), .hit_kern(hit_kern), .hit_ro(hit_ro),
        .fill_en(final_ok), .fill_rg(rg_q), .fill_vpn(vpn_q), .fill_pfn(pte_pfn),
        .fill_kern(pte_kern), .fill_ro(pte_ro), .flush_proc(ctx_switch)
    );

    // Walk sequencer: decode/hit on accept, then one or two table reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            rg_q      <= RG_ASC;
            vpn_q     <= '0;
            off_q     <= '0;
            pva_off_q <= '0;
            user_q    <= 1'b0;
            wr_q      <= 1'b0;
            addr_q    <= '0;
            fault_q   <= FLT_NONE;
            paddr_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    rg_q      <= rg_in;
                    vpn_q     <= vpn_in;
                    off_q     <= req_vaddr[OFF_W-1:0];
                    pva_off_q <= pva_off_in;
                    user_q    <= req_user;
                    wr_q      <= req_write;
                    addr_q    <= spte_addr;
                    paddr_q   <= '0;
                    if (rsv_flt) begin
                        fault_q <= FLT_RSV;
                        st      <= ST_RESP;
                    end else if (len_flt) begin
                        fault_q <= FLT_LEN;
                        st      <= ST_RESP;
                    end else if (hit) begin
                        fault_q <= hit_bad ? FLT_ACCESS : FLT_NONE;
                        paddr_q <= hit_bad ? '0 : {hit_pfn, req_vaddr[OFF_W-1:0]};
                        st      <= ST_RESP;
                    end else begin
                        st <= ST_SYSRD;
                    end
                end
                ST_SYSRD: if (mem_ack) begin
                    if (!pte_valid) begin
                        fault_q <= FLT_SYS_INV;
                        st      <= ST_RESP;
                    end else if (rg_q == RG_SYS) begin
                        fault_q <= prot_bad ? FLT_ACCESS : FLT_NONE;
                        paddr_q <= prot_bad ? '0 : {pte_pfn, off_q};
                        st      <= ST_RESP;
                    end else begin
                        addr_q <= {2'b00, pte_pfn, pva_off_q};
                        st     <= ST_PROCRD;
                    end
                end
                ST_PROCRD: if (mem_ack) begin
                    if (!pte_valid) begin
                        fault_q <= FLT_PROC_INV;
                    end else begin
                        fault_q <= prot_bad ? FLT_ACCESS : FLT_NONE;
                        paddr_q <= prot_bad ? '0 : {pte_pfn, off_q};
                    end
                    st <= ST_RESP;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign mem_req   = (st == ST_SYSRD) || (st == ST_PROCRD);
    assign mem_addr  = addr_q;
    assign rsp_valid = (st == ST_RESP);
    assign rsp_fault = fault_q;
    assign rsp_paddr = paddr_q;
endmodule

// File: rtl/segx_xlate_chk.sv
// Protocol and fault properties for segx_xlate, bound to every instance.
// Assumes the input rules stated in the header of segx_xlate.
module segx_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic [20:0] asc_len,
    input logic [20:0] dsc_len,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        rsp_valid,
    input logic [2:0]  rsp_fault,
    input logic [29:0] rsp_paddr
);
    assert_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_vaddr[31:30] == 2'b11)
        |=> (rsp_valid && rsp_fault == 3'd2 && !mem_req));

    assert_asc_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_vaddr[31:30] == 2'b00 && req_vaddr[29:9] >= asc_len)
        |=> (rsp_valid && rsp_fault == 3'd1));

    assert_dsc_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_vaddr[31:30] == 2'b01 && req_vaddr[29:9] < dsc_len)
        |=> (rsp_valid && rsp_fault == 3'd1));

    assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == 30'd0));

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid));
endmodule

bind segx_xlate segx_xlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .asc_len(asc_len), .dsc_len(dsc_len),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/segx_xlate_tb_top.sv
// Self-checking bench: page tables are a fixed function of address, responses come from a model.
module segx_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_user = 1'b0, req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        ctx_switch = 1'b0;
    logic [31:0] sys_base = 32'h0010_0000, asc_base = 32'h8000_4000, dsc_base = 32'h7F80_8800;
    logic [20:0] sys_len = 21'd4096, asc_len = 21'd1024, dsc_len = 21'h1F_FE00;
    logic        mem_req, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [29:0] rsp_paddr;

    int n_chk = 0, n_bad = 0, n_reads = 0, dly = 0;
    logic [31:0] mem_log [2];
    bit done = 1'b0;

    always #10 clk = ~clk;

    segx_xlate dut_i (.*);

    function automatic logic [31:0] pte_of(input logic [31:0] a);
        logic [31:0] h;
        h = (a ^ (a >> 5)) * 32'h2545_F491;
        h = h ^ (h >> 15);
        return {(h[3:0] != 4'd0), h[4] & h[5], h[6] & h[7], 8'h00, h[31:11]};
    endfunction

    function automatic void model(input logic [31:0] va, input logic u, input logic w,
                                  output logic [2:0] f, output logic [29:0] pa, output int nr,
                                  output logic [31:0] a1, output logic [31:0] a2);
        logic [1:0]  rg;
        logic [20:0] vpn;
        logic [31:0] pva, spte, pte;
        rg = va[31:30]; vpn = va[29:9];
        f = 3'd0; pa = '0; nr = 0; a1 = '0; a2 = '0; pte = '0;
        if (rg == 2'd3) begin f = 3'd2; return; end
        if ((rg == 2'd0 && vpn >= asc_len) || (rg == 2'd1 && vpn < dsc_len) ||
            (rg == 2'd2 && vpn >= sys_len)) begin f = 3'd1; return; end
        if (rg == 2'd2) begin
            a1 = sys_base + {9'd0, vpn, 2'b00}; nr = 1; pte = pte_of(a1);
            if (!pte[31]) begin f = 3'd3; return; end
        end else begin
            pva = ((rg == 2'd1) ? dsc_base : asc_base) + {9'd0, vpn, 2'b00};
            if (pva[31:30] != 2'b10 || pva[29:9] >= sys_len) begin f = 3'd1; return; end
            a1 = sys_base + {9'd0, pva[29:9], 2'b00}; nr = 1; spte = pte_of(a1);
            if (!spte[31]) begin f = 3'd3; return; end
            a2 = {2'b00, spte[20:0], pva[8:0]}; nr = 2; pte = pte_of(a2);
            if (!pte[31]) begin f = 3'd4; return; end
        end
        if ((u && pte[30]) || (w && pte[29])) begin f = 3'd5; return; end
        pa = {pte[20:0], va[8:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Page-table memory: acknowledges a pending read after 0..3 cycles.
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (dly == 0) begin
                    mem_rdata = pte_of(mem_addr);
                    mem_ack = 1'b1;
                    if (n_reads < 2) mem_log[n_reads] = mem_addr;
                    n_reads++;
                    dly = $urandom_range(0, 3);
                end else dly--;
            end
        end
    end

    task automatic xlate(input logic [31:0] va, input logic u, input logic w,
                         output logic [2:0] f, output logic [29:0] pa, output int reads, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        n_reads = 0;
        req_vaddr = va; req_user = u; req_write = w; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
        chk(rsp_valid, "R10 response missing", 64'(rsp_valid), 64'd1);
        f = rsp_fault; pa = rsp_paddr; reads = n_reads;
    endtask

    task automatic run_one(input logic [31:0] va, input logic u, input logic w,
                           output logic [2:0] f, output int reads, output int lat);
        logic [2:0]  ef;
        logic [29:0] pa, epa;
        logic [31:0] ea1, ea2;
        int          enr;
        string       t;
        xlate(va, u, w, f, pa, reads, lat);
        model(va, u, w, ef, epa, enr, ea1, ea2);
        case (ef)
            3'd0:    t = (va[31:30] == 2'b10) ? "R3 result" : "R4 result";
            3'd1:    t = "R2 length";
            3'd2:    t = "R1 reserved";
            3'd5:    t = "R7 protection";
            default: t = "R6 invalid";
        endcase
        chk(f == ef, t, 64'(f), 64'(ef));
        chk(pa == epa, "R5 paddr", 64'(pa), 64'(epa));
        chk(reads == 0 || reads == enr, "R8 read count", 64'(reads), 64'(enr));
        if (reads > 0) chk(mem_log[0] == ea1, "R3 first read", 64'(mem_log[0]), 64'(ea1));
        if (reads > 1) chk(mem_log[1] == ea2, "R4 second read", 64'(mem_log[1]), 64'(ea2));
    endtask

    task automatic ctx(input logic [31:0] ab, input logic [20:0] al);
        @(negedge clk);
        asc_base = ab; asc_len = al; ctx_switch = 1'b1;
        @(negedge clk);
        ctx_switch = 1'b0;
    endtask

    function automatic logic [31:0] sys_va(input logic [20:0] vpn);
        return {2'b10, vpn, 9'h055};
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [2:0]  f, f2;
        logic [29:0] pa;
        logic [31:0] va;
        logic [20:0] pg [9];
        int reads, lat, k;
        void'($urandom(32'd7321));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req, "R12 reset state",
            64'({req_ready, rsp_valid, mem_req}), 64'b100);

        // R1: reserved quarter faults immediately.
        run_one(32'hC000_1234, 1'b0, 1'b0, f, reads, lat);
        chk(lat == 0 && reads == 0, "R1 latency/reads", 64'(lat + reads), 64'd0);

        // R2: boundaries in each direction.
        run_one({2'b00, asc_len - 21'd1, 9'h0}, 1'b0, 1'b0, f, reads, lat);
        run_one({2'b00, asc_len, 9'h0}, 1'b0, 1'b0, f, reads, lat);
        chk(f == 3'd1, "R2 ascending limit", 64'(f), 64'd1);
        run_one({2'b01, dsc_len - 21'd1, 9'h0}, 1'b0, 1'b0, f, reads, lat);
        chk(f == 3'd1, "R2 descending limit", 64'(f), 64'd1);
        run_one({2'b01, dsc_len, 9'h0}, 1'b0, 1'b0, f, reads, lat);
        chk(f != 3'd1, "R2 descending lowest legal", 64'(f), 64'd0);

        // R8: a repeat access hits.
        run_one(sys_va(21'd2400), 1'b0, 1'b0, f, reads, lat);
        run_one(sys_va(21'd2400), 1'b0, 1'b0, f2, reads, lat);
        chk(reads == 0 && lat == 0, "R8 hit timing", 64'(reads * 256 + lat), 64'd0);

        // R9: context switch drops process entries only.
        run_one({2'b00, 21'd5, 9'h010}, 1'b1, 1'b0, f, reads, lat);
        ctx(asc_base, asc_len);
        run_one(sys_va(21'd2400), 1'b0, 1'b0, f, reads, lat);
        chk(reads == 0, "R9 system entry kept", 64'(reads), 64'd0);
        run_one({2'b00, 21'd5, 9'h010}, 1'b1, 1'b0, f, reads, lat);
        chk(f == 3'd1 || f == 3'd3 || reads > 0, "R9 process entry flushed", 64'(reads), 64'd1);

        // R11: nine fresh filling pages evict the first.
        k = 0;
        for (int v = 2500; v < 2900 && k < 9; v++) begin
            if (pte_of(sys_base + {9'd0, 21'(v), 2'b00}) >> 31) begin pg[k] = 21'(v); k++; end
        end
        for (int i = 0; i < 9; i++) run_one(sys_va(pg[i]), 1'b0, 1'b0, f, reads, lat);
        for (int i = 1; i < 9; i++) begin
            run_one(sys_va(pg[i]), 1'b0, 1'b0, f, reads, lat);
            chk(reads == 0, "R11 retained entry", 64'(reads), 64'd0);
        end
        run_one(sys_va(pg[0]), 1'b0, 1'b0, f, reads, lat);
        chk(reads == 1, "R11 evicted entry", 64'(reads), 64'd1);

        // R7: privileged-only and read-only pages.
        for (int v = 3000; v < 3400; v++) begin
            logic [31:0] p;
            p = pte_of(sys_base + {9'd0, 21'(v), 2'b00});
            if (p[31] && p[30] && !p[29]) begin
                run_one(sys_va(21'(v)), 1'b1, 1'b0, f, reads, lat);
                chk(f == 3'd5, "R7 user on privileged page", 64'(f), 64'd5);
                run_one(sys_va(21'(v)), 1'b0, 1'b0, f, reads, lat);
                chk(f == 3'd0, "R7 privileged access", 64'(f), 64'd0);
                break;
            end
        end
        for (int v = 3400; v < 3800; v++) begin
            logic [31:0] p;
            p = pte_of(sys_base + {9'd0, 21'(v), 2'b00});
            if (p[31] && !p[30] && p[29]) begin
                run_one(sys_va(21'(v)), 1'b0, 1'b1, f, reads, lat);
                chk(f == 3'd5, "R7 write to read-only", 64'(f), 64'd5);
                break;
            end
        end

        // R4: process table running past the system length, or outside system space.
        ctx(32'h8000_0000 + 32'd4096 * 32'd512 - 32'd8, 21'd100);
        run_one({2'b00, 21'd1, 9'h0}, 1'b0, 1'b0, f, reads, lat);
        run_one({2'b00, 21'd2, 9'h0}, 1'b0, 1'b0, f, reads, lat);
        chk(f == 3'd1 && reads == 0, "R4 system length on table", 64'(f), 64'd1);
        ctx(32'h0000_1000, 21'd100);
        run_one({2'b00, 21'd3, 9'h0}, 1'b0, 1'b0, f, reads, lat);
        chk(f == 3'd1 && reads == 0, "R4 table outside system space", 64'(f), 64'd1);
        ctx(32'h8000_4000, 21'd1024);

        // Random mix across all regions and boundaries.
        for (int n = 0; n < 700; n++) begin
            int r;
            logic [20:0] vpn;
            r = $urandom_range(0, 9);
            if (r < 3) begin
                vpn = 21'($urandom_range(0, 1044));
                va = {2'b00, vpn, 9'($urandom)};
            end else if (r < 6) begin
                vpn = 21'($urandom_range(32'h1F_FDEC, 32'h1F_FFFF));
                va = {2'b01, vpn, 9'($urandom)};
            end else if (r < 9) begin
                vpn = ($urandom_range(0, 3) == 0) ? 21'($urandom_range(4086, 4105))
                                                  : 21'($urandom_range(0, 2047));
                va = {2'b10, vpn, 9'($urandom)};
            end else begin
                va = {2'b11, 30'($urandom)};
            end
            run_one(va, 1'($urandom), 1'($urandom), f, reads, lat);
        end

        finish_run();
    end
endmodule